// File: doc/BRIEF.md
# Fixed-Table Prefix Code Bit Packer

This block turns a stream of 3-bit symbols into a dense serial bitstream. Each symbol is replaced by a prefix-free codeword of one to six bits from a fixed table. The table is shaped for a source whose eight symbols occur with probabilities 1/2, 1/4, 1/8, 1/16, and 1/64 for each of the last four. Codewords are concatenated most significant bit first into a bit accumulator. A byte is handed out on a valid/ready port as soon as eight bits are available, and any remaining bits stay behind for the next byte.

A flush command closes the stream. It pads the bits still pending with zeros, marks that byte as the last one, and reports how many of its bits carry data. For the design source the code spends 2 bits per symbol on average, where a plain 3-bit code would spend 3. That is a ratio of 3/2 and equals the source entropy.

Symbols enter on a valid/ready handshake. The input is held off only while a whole byte is waiting and the output side refuses it, or while a flush is being completed.

Top module: `hufEncoder`

## Requirements
- R1: Symbol value k on `symIn` selects codeword k+1. The codewords are: value 0 → `1`, 1 → `01`, 2 → `001`, 3 → `0001`, 4 → `000001`, 5 → `000000`, 6 → `000011`, 7 → `000010`, written first bit leftmost.
- R2: Codewords are packed in acceptance order with the first code bit leading. The first bit of the stream lands in bit 7 of the first byte, and the following bits fill downward toward bit 0.
- R3: When a handshake edge leaves eight or more bits pending with no byte held on the output, `byteValid` is high after the next rising edge. The one exception is a flush-only command.
- R4: `symReady` is low only while a flush is in progress, or while eight or more bits are pending and a byte is held with `byteReady` low. A held byte keeps `byteValid` high and `byteOut` unchanged until it is taken. Pending bits never exceed 13.
- R5: A flush pads the pending bits with zeros in the low positions of a final byte. That byte carries `byteLast` = 1, and `byteBits` gives the count of data bits, from 1 to 8.
- R6: A flush-only command given when no bits are pending is ignored: no byte is produced.
- R7: A symbol and a flush accepted in the same cycle put that symbol's codeword into the stream before the padding.
- R8: Every byte that is not the final one carries `byteLast` = 0 and `byteBits` = 8.
- R9: During and right after reset, `byteValid` is 0 and `symReady` is 1.
- R10: A 64-symbol block that follows the design probabilities exactly packs into 16 bytes, which is 2 bits per symbol.
- R11: If exactly 8 bits are pending when the flush takes effect, they leave as a single last byte with `byteBits` = 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| symValid | input | 1 | A symbol is offered |
| symReady | output | 1 | Symbol and flush commands are accepted this cycle |
| symIn | input | 3 | Symbol value 0 to 7 |
| flushIn | input | 1 | Flush command, accepted with `symReady` |
| byteValid | output | 1 | A packed byte is offered |
| byteReady | input | 1 | Downstream takes the byte |
| byteOut | output | 8 | Packed byte, first stream bit in bit 7 |
| byteLast | output | 1 | This byte ends the flushed stream |
| byteBits | output | 4 | Count of data bits in the byte |

## Verification
In one cycle the packer can both release a full byte from the accumulator and append a new codeword, and a flush can arrive together with a symbol. The tests provoke the first case with back-to-back six-bit codes under a stalled and a randomly toggling `byteReady`. They provoke the second by sending a symbol with a flush, including the case where exactly one byte is then pending. Each result is judged by decoding the captured bytes bit by bit with a code tree and comparing the result with the sent symbols. The tests also check the last flag, the count of data bits, and the zero padding.

// File: rtl/hufEncPkg.sv
`timescale 1ns/1ps
package hufEncPkg;
  localparam int SYM_W = 3;
  localparam int MAX_CODE_LEN = 6;
  localparam int LEN_W = $clog2(MAX_CODE_LEN + 1);

  // strobes from control to datapath
  typedef struct packed {
    logic append;      // add the current codeword
    logic drainByte;   // move the oldest full byte to the output register
    logic drainFinal;  // move the padded remainder as the last byte
  } dpCtrlT;
endpackage

// File: rtl/hufCodeRom.sv
`timescale 1ns/1ps
module hufCodeRom
  import hufEncPkg::*;
(
  input  logic [SYM_W-1:0]        symIn,
  output logic [MAX_CODE_LEN-1:0] codeBits,
  output logic [LEN_W-1:0]        codeLen
);
  // values 0..3: (k zeros then a one); values 4..7: four zeros and a 2-bit tail
  always_comb begin
    if (!symIn[SYM_W-1]) begin
      codeLen  = LEN_W'(symIn[1:0]) + LEN_W'(1);
      codeBits = MAX_CODE_LEN'(1);
    end else begin
      codeLen  = LEN_W'(MAX_CODE_LEN);
      codeBits = {{(MAX_CODE_LEN-2){1'b0}}, symIn[1], ~symIn[0]};
    end
  end

  // R1
  always_comb begin
    code_len_range_chk: assert (codeLen >= LEN_W'(1) && codeLen <= LEN_W'(MAX_CODE_LEN));
  end
endmodule

// File: rtl/hufPackCtrl.sv
`timescale 1ns/1ps
module hufPackCtrl
  import hufEncPkg::*;
#(
  parameter int OUT_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             symValid,
  input  logic             flushIn,
  input  logic             byteReady,
  input  logic [CNT_W-1:0] pendCnt,
  output logic             symReady,
  output logic             byteValid,
  output dpCtrlT           dpCtrl
);
  localparam logic [CNT_W-1:0] OUT_CNT = CNT_W'(OUT_W);

  logic flushPend;
  logic outFree, fullPend, symAcc, flushAcc, flushOnlyExact;

  always_comb begin
    outFree        = !byteValid || byteReady;
    fullPend       = pendCnt >= OUT_CNT;
    symReady       = !flushPend && !(fullPend && !outFree);
    symAcc         = symValid && symReady;
    flushAcc       = flushIn && symReady;
    flushOnlyExact = flushAcc && !symValid && (pendCnt == OUT_CNT);

    dpCtrl.append     = symAcc;
    dpCtrl.drainByte  = outFree && (flushPend ? (pendCnt > OUT_CNT)
                                              : (fullPend && !flushOnlyExact));
    dpCtrl.drainFinal = outFree && flushPend && (pendCnt != '0) && (pendCnt <= OUT_CNT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flushPend <= 1'b0;
      byteValid <= 1'b0;
    end else begin
      if (dpCtrl.drainFinal)
        flushPend <= 1'b0;
      else if (flushAcc && (symValid || pendCnt != '0))
        flushPend <= 1'b1;

      if (dpCtrl.drainByte || dpCtrl.drainFinal)
        byteValid <= 1'b1;
      else if (byteReady)
        byteValid <= 1'b0;
    end
  end

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteValid && !byteReady |=> byteValid);

  // R5
  flush_blocks_input_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushAcc && symValid |=> !symReady);
endmodule

// File: rtl/hufPackDatapath.sv
`timescale 1ns/1ps
module hufPackDatapath
  import hufEncPkg::*;
#(
  parameter int OUT_W  = 8,
  parameter int ACC_W  = 13,
  parameter int CNT_W  = 4,
  parameter int BITS_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtrlT                  dpCtrl,
  input  logic [MAX_CODE_LEN-1:0] codeBits,
  input  logic [LEN_W-1:0]        codeLen,
  output logic [CNT_W-1:0]        pendCnt,
  output logic [OUT_W-1:0]        byteOut,
  output logic                    byteLast,
  output logic [BITS_W-1:0]       byteBits
);
  localparam logic [CNT_W-1:0] OUT_CNT = CNT_W'(OUT_W);

  logic [ACC_W-1:0] accReg, accNext;
  logic [CNT_W-1:0] cntMid, cntNext;
  logic [OUT_W-1:0] byteFull, byteTail;

  // pending bits sit right-justified; the oldest is at position pendCnt-1
  always_comb begin
    if (dpCtrl.drainByte)       cntMid = pendCnt - OUT_CNT;
    else if (dpCtrl.drainFinal) cntMid = '0;
    else                        cntMid = pendCnt;

    if (dpCtrl.append) begin
      accNext = (accReg << codeLen) | ACC_W'(codeBits);
      cntNext = cntMid + CNT_W'(codeLen);
    end else begin
      accNext = accReg;
      cntNext = cntMid;
    end

    byteFull = OUT_W'(accReg >> (pendCnt - OUT_CNT));
    byteTail = OUT_W'(accReg << (OUT_CNT - pendCnt));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg   <= '0;
      pendCnt  <= '0;
      byteOut  <= '0;
      byteLast <= 1'b0;
      byteBits <= '0;
    end else begin
      accReg  <= accNext;
      pendCnt <= cntNext;
      if (dpCtrl.drainByte) begin
        byteOut  <= byteFull;
        byteLast <= 1'b0;
        byteBits <= BITS_W'(OUT_W);
      end else if (dpCtrl.drainFinal) begin
        byteOut  <= byteTail;
        byteLast <= 1'b1;
        byteBits <= BITS_W'(pendCnt);
      end
    end
  end

  // R4
  acc_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= CNT_W'(ACC_W));

  // R4
  one_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(dpCtrl.drainByte && dpCtrl.drainFinal));
endmodule

// File: rtl/hufEncoder.sv
`timescale 1ns/1ps
module hufEncoder
  import hufEncPkg::*;
#(
  parameter  int OUT_W  = 8,
  localparam int BITS_W = $clog2(OUT_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              symValid,
  output logic              symReady,
  input  logic [SYM_W-1:0]  symIn,
  input  logic              flushIn,
  output logic              byteValid,
  input  logic              byteReady,
  output logic [OUT_W-1:0]  byteOut,
  output logic              byteLast,
  output logic [BITS_W-1:0] byteBits
);
  localparam int ACC_W = OUT_W + MAX_CODE_LEN - 1;
  localparam int CNT_W = $clog2(ACC_W + 1);

  dpCtrlT                  dpCtrl;
  logic [MAX_CODE_LEN-1:0] codeBits;
  logic [LEN_W-1:0]        codeLen;
  logic [CNT_W-1:0]        pendCnt;

  hufCodeRom uRom (
    .symIn   (symIn),
    .codeBits(codeBits),
    .codeLen (codeLen)
  );

  hufPackCtrl #(.OUT_W(OUT_W), .CNT_W(CNT_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .symValid (symValid),
    .flushIn  (flushIn),
    .byteReady(byteReady),
    .pendCnt  (pendCnt),
    .symReady (symReady),
    .byteValid(byteValid),
    .dpCtrl   (dpCtrl)
  );

  hufPackDatapath #(.OUT_W(OUT_W), .ACC_W(ACC_W), .CNT_W(CNT_W), .BITS_W(BITS_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtrl  (dpCtrl),
    .codeBits(codeBits),
    .codeLen (codeLen),
    .pendCnt (pendCnt),
    .byteOut (byteOut),
    .byteLast(byteLast),
    .byteBits(byteBits)
  );

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteValid && !byteReady |=> $stable(byteOut) && $stable(byteLast));

  // R3
  prompt_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendCnt >= CNT_W'(OUT_W)) && !byteValid && !flushIn |=> byteValid);

  // R6
  empty_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushIn && !symValid && symReady && !byteValid && pendCnt == '0 |=> !byteValid);

  // R8
  full_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteValid && !byteLast |-> byteBits == BITS_W'(OUT_W));

  // R5
  last_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteValid && byteLast |-> byteBits != '0 && byteBits <= BITS_W'(OUT_W));
endmodule

// File: tb/sim_hufEncoder.sv
`timescale 1ns/1ps
module sim_hufEncoder;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       symValid = 1'b0;
  logic [2:0] symIn = '0;
  logic       flushIn = 1'b0;
  logic       byteReady = 1'b1;
  logic       symReady, byteValid, byteLast;
  logic [7:0] byteOut;
  logic [3:0] byteBits;

  always #4 clk = ~clk;  // 125 MHz

  hufEncoder u0 (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symReady(symReady),
    .symIn(symIn), .flushIn(flushIn), .byteValid(byteValid),
    .byteReady(byteReady), .byteOut(byteOut), .byteLast(byteLast),
    .byteBits(byteBits)
  );

  int nRun = 0, nFail = 0;
  int readyMode = 0;          // 0 always ready, 1 random, 2 stalled
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] capByte [0:1023];
  logic       capLast [0:1023];
  logic [3:0] capBits [0:1023];
  int capN = 0;
  int sentSym [0:2047];
  int sentN = 0;
  int stallSeen = 0;
  int bitBuf [0:8207];
  int nBits = 0;
  logic [15:0] rng = 16'h1D2B;

  // output side: pick ready, then record a handshake due at the next edge
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (readyMode)
      0: byteReady = 1'b1;
      1: byteReady = lfsr[0];
      default: byteReady = 1'b0;
    endcase
    if (byteValid && byteReady && capN < 1024) begin
      capByte[capN] = byteOut;
      capLast[capN] = byteLast;
      capBits[capN] = byteBits;
      capN++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sendCmd(input int k, input bit sv, input bit fl);
    @(negedge clk);
    #1;
    symValid = sv; symIn = k[2:0]; flushIn = fl;
    #1;
    while (!symReady) begin
      stallSeen++;
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    if (sv) begin sentSym[sentN] = k; sentN++; end
    #1;
    symValid = 1'b0; flushIn = 1'b0;
  endtask

  task automatic startStream();
    capN = 0; sentN = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // codeword of value k per R1, as a length and right-aligned bits
  function automatic int codeLenOf(input int k);
    return (k < 4) ? k + 1 : 6;
  endfunction
  function automatic int codeValOf(input int k);
    case (k)
      0: return 1;  1: return 1;  2: return 1;  3: return 1;
      4: return 1;  5: return 0;  6: return 3;  default: return 2;
    endcase
  endfunction

  // flatten captured bytes, check framing, decode with the code tree
  task automatic checkStream(input string req);
    int badFrame = 0, badPad = 0, bad = 0, idx = 0, pos = 0, s;
    nBits = 0;
    for (int i = 0; i < capN; i++) begin
      int n = capLast[i] ? int'(capBits[i]) : 8;
      if (i < capN - 1 && (capLast[i] || capBits[i] != 4'd8)) badFrame++;
      if (i == capN - 1 && !capLast[i]) badFrame++;
      for (int b = 0; b < 8; b++) begin
        if (b < n) begin bitBuf[nBits] = int'(capByte[i][7-b]); nBits++; end
        else if (capByte[i][7-b]) badPad++;
      end
    end
    for (int z = 0; z < 8; z++) bitBuf[nBits + z] = 0;
    while (pos < nBits) begin
      if (bitBuf[pos] == 1)        begin s = 0; pos += 1; end
      else if (bitBuf[pos+1] == 1) begin s = 1; pos += 2; end
      else if (bitBuf[pos+2] == 1) begin s = 2; pos += 3; end
      else if (bitBuf[pos+3] == 1) begin s = 3; pos += 4; end
      else begin
        s = (bitBuf[pos+4] == 1) ? ((bitBuf[pos+5] == 1) ? 6 : 7)
                                 : ((bitBuf[pos+5] == 1) ? 4 : 5);
        pos += 6;
      end
      if (idx >= sentN || sentSym[idx] != s) bad++;
      idx++;
    end
    check(badFrame == 0, "R8", {req, " last flag only on final byte"}, badFrame, 0);
    check(badPad == 0, "R5", {req, " zero padding"}, badPad, 0);
    check(idx == sentN && bad == 0, "R2", {req, " decoded symbols"}, idx - bad, sentN);
  endtask

  task automatic tReset();
    rstN = 1'b0;
    settle(3);
    check(byteValid == 1'b0, "R9", "byteValid in reset", byteValid, 0);
    rstN = 1'b1;
    settle(1);
    check(byteValid == 1'b0, "R9", "byteValid after reset", byteValid, 0);
    check(symReady == 1'b1, "R9", "symReady after reset", symReady, 1);
  endtask

  task automatic tSingleFlush();
    startStream();
    sendCmd(2, 1, 0);
    sendCmd(0, 0, 1);
    settle(10);
    check(capN == 1, "R5", "byte count", capN, 1);
    check(capByte[0] == 8'h20, "R5", "padded byte", capByte[0], 8'h20);
    check(capLast[0] && capBits[0] == 4'd3, "R5", "last and bit count", capBits[0], 3);
  endtask

  task automatic tFlushWithSym();
    startStream();
    sendCmd(3, 1, 1);
    settle(10);
    check(capN == 1 && capByte[0] == 8'h10, "R7", "symbol before pad", capByte[0], 8'h10);
    check(capLast[0] && capBits[0] == 4'd4, "R7", "bit count", capBits[0], 4);
  endtask

  task automatic tEmptyFlush();
    startStream();
    sendCmd(0, 0, 1);
    settle(20);
    check(capN == 0, "R6", "no byte from empty flush", capN, 0);
    sendCmd(0, 1, 1);
    settle(10);
    check(capN == 1 && capByte[0] == 8'h80 && capBits[0] == 4'd1, "R6",
          "next stream unaffected", capByte[0], 8'h80);
  endtask

  task automatic tLatency();
    startStream();
    sendCmd(4, 1, 0);
    sendCmd(5, 1, 0);
    @(negedge clk);
    check(byteValid == 1'b0, "R3", "byteValid one edge after 12 bits", byteValid, 0);
    @(negedge clk);
    check(byteValid == 1'b1, "R3", "byteValid two edges after", byteValid, 1);
    check(byteOut == 8'h04, "R3", "first byte", byteOut, 8'h04);
    sendCmd(0, 0, 1);
    settle(10);
    check(capN == 2 && capByte[1] == 8'h00 && capBits[1] == 4'd4 && capLast[1], "R5",
          "tail of four zero bits", capBits[1], 4);
  endtask

  task automatic tAllCodes();
    int expN = 0, mism = 0;
    startStream();
    for (int k = 0; k < 8; k++) sendCmd(k, 1, k == 7);
    settle(20);
    checkStream("all codes");
    for (int k = 0; k < 8; k++)
      for (int b = codeLenOf(k) - 1; b >= 0; b--) begin
        if (expN >= nBits || bitBuf[expN] != ((codeValOf(k) >> b) & 1)) mism++;
        expN++;
      end
    check(nBits == 34, "R1", "total code bits", nBits, 34);
    check(mism == 0, "R1", "code bit mismatches", mism, 0);
    check(capN == 5 && capBits[4] == 4'd2, "R5", "final byte bits", capBits[4], 2);
  endtask

  task automatic tDesignSource();
    startStream();
    for (int i = 0; i < 64; i++) begin
      int s;
      if (i % 2 == 0)       s = 0;
      else if (i % 4 == 1)  s = 1;
      else if (i % 8 == 3)  s = 2;
      else if (i % 16 == 7) s = 3;
      else                  s = 4 + i / 16;
      sendCmd(s, 1, i == 63);
    end
    settle(20);
    check(capN == 16, "R10", "bytes for 64 design symbols", capN, 16);
    check(capLast[15] && capBits[15] == 4'd8, "R11", "aligned last byte count",
          capBits[15], 8);
    checkStream("R10 design source");
  endtask

  task automatic tBackpressure();
    logic [7:0] held;
    startStream();
    readyMode = 2;
    for (int i = 0; i < 3; i++) sendCmd(4, 1, 0);
    @(negedge clk); #2;
    check(symReady == 1'b0, "R4", "input stalled with full byte held", symReady, 0);
    held = byteOut;
    settle(5);
    check(byteValid && byteOut == held, "R4", "held byte stable", byteOut, held);
    readyMode = 1;
    stallSeen = 0;
    for (int i = 0; i < 150; i++) begin
      rng = {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
      sendCmd(int'(rng[2:0]), 1, i == 149);
    end
    readyMode = 0;
    settle(100);
    check(stallSeen > 0, "R4", "stalls under random ready", stallSeen > 0, 1);
    checkStream("R4 backpressure");
  endtask

  initial begin
    tReset();
    tSingleFlush();
    tFlushWithSym();
    tEmptyFlush();
    tLatency();
    tAllCodes();
    tDesignSource();
    tBackpressure();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule